// File: doc/BRIEF.md
# Multi-Core Interrupt Send Router

This block sits at the top of an inter-processor interrupt controller that serves `NUM_CORES` cores. Every bus access carries the ID of the core that issued it. The router passes the access to that core's own register file. Each register file holds a status word, an enable word and eight mailbox words, and it drives one interrupt line. The interrupt line is high whenever a status bit and the matching enable bit are both set.

One offset in the per-core window is a send command, and it does not act on the requester's registers. A write there names a target core and a 5-bit vector. The router turns the vector into a one-hot mask and applies it as a set-write to the target's status. Any core can therefore interrupt any other core, or itself, with one write.

The ID lookup maps an ID directly to the core index and checks that the index is in range. A requester or target outside the range raises the decode-error flag, and nothing changes. Read data and the error flag are combinational in the access cycle. Writes take effect at the next clock edge.

Top module: `ipi_send_router`

## Requirements
- R1: After synchronous reset, every core's status, enable and mailbox words read zero and every interrupt line is low.
- R2: An access whose requester ID is NUM_CORES or greater raises `rsp_err` in its cycle, returns read data zero and changes no register of any core.
- R3: Offset 0x04 is the enable word of the requester's core and reads back what was last written. Offset 0x00 reads that core's status. Reads never change state.
- R4: A write to offset 0x08 ORs the write data into the requester's status. A write to offset 0x0C clears every status bit that is 1 in the write data.
- R5: `irq[i]` is high exactly when status and enable of core i share a set bit, and it reflects a write from the cycle after that write.
- R6: Offsets 0x20, 0x24, through 0x3C are eight mailbox words per core (word index = offset bits 4:2). Each core's mailbox words are separate from every other core's.
- R7: A write to offset 0x40 is a send command. Data bits 25:16 select the target core ID and bits 4:0 the vector. The router sets status bit `vector` of the target core. All other data bits are ignored.
- R8: A send whose target ID is NUM_CORES or greater raises `rsp_err` and changes no state. `rsp_err` is never raised without `req_valid`.
- R9: A send whose target is the requesting core itself is accepted and sets that core's own status bit.
- R10: Writes to the status offset 0x00 and to unmapped offsets are ignored without error, and unmapped offsets read zero.
- R11: Reads of the set (0x08), clear (0x0C) and send (0x40) offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset inside the per-core window |
| req_wdata | input | 32 | Write data |
| req_id | input | 10 | ID of the requesting core |
| rsp_rdata | output | 32 | Read data, valid in the access cycle |
| rsp_err | output | 1 | Decode error for the current access |
| irq | output | NUM_CORES | Per-core interrupt lines |

## Verification
The bench builds the router with `NUM_CORES = 3`. With three cores it can check that one core's writes stay out of the others' registers, and it can send to a third core that is neither the sender nor core 0. The ID range check can then fail at 3, just past the last core, and at the 10-bit maximum 1023, for both requester and target. A run of random accesses mixes sends, set and clear writes and enable changes. Because of this mix, interrupt lines rise and fall from both local writes and writes from other cores.

// File: rtl/ipi_rt_pkg.sv
package ipi_rt_pkg;

    localparam int OFS_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ID_W    = 10;
    localparam int VEC_W   = 5;
    localparam int TGT_LSB = 16;
    localparam int MBOX_N  = 8;
    localparam int MBOX_IW = $clog2(MBOX_N);

    localparam logic [OFS_W-1:0] OFS_STATUS  = 8'h00;
    localparam logic [OFS_W-1:0] OFS_ENABLE  = 8'h04;
    localparam logic [OFS_W-1:0] OFS_SET     = 8'h08;
    localparam logic [OFS_W-1:0] OFS_CLEAR   = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_MBOX_LO = 8'h20;
    localparam logic [OFS_W-1:0] OFS_MBOX_HI = OFS_MBOX_LO + OFS_W'(4 * (MBOX_N - 1));
    localparam logic [OFS_W-1:0] OFS_SEND    = 8'h40;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOCAL_RD,
        OP_LOCAL_WR,
        OP_SEND,
        OP_REJECT
    } op_kind_e;

    typedef struct packed {
        logic              en;
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] data;
    } core_wr_t;

    function automatic logic [DATA_W-1:0] vec_to_mask(input logic [VEC_W-1:0] v);
        return DATA_W'(1) << v;
    endfunction

    function automatic logic is_mbox(input logic [OFS_W-1:0] ofs);
        return (ofs >= OFS_MBOX_LO) && (ofs <= OFS_MBOX_HI) && (ofs[1:0] == 2'b00);
    endfunction

    function automatic logic [MBOX_IW-1:0] mbox_idx(input logic [OFS_W-1:0] ofs);
        return MBOX_IW'((ofs - OFS_MBOX_LO) >> 2);
    endfunction

    function automatic op_kind_e classify(input logic valid, input logic write,
                                          input logic [OFS_W-1:0] ofs, input logic req_ok);
        if (!valid)                 return OP_IDLE;
        if (!req_ok)                return OP_REJECT;
        if (!write)                 return OP_LOCAL_RD;
        if (ofs == OFS_SEND)        return OP_SEND;
        return OP_LOCAL_WR;
    endfunction

endpackage

// File: rtl/ipi_id_map.sv
module ipi_id_map
    import ipi_rt_pkg::*;
#(
    parameter int NUM_CORES = 1
) (
    input  logic [ID_W-1:0]      id,
    output logic [NUM_CORES-1:0] hit,
    output logic                 found
);
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
        assign hit[i] = (id == ID_W'(i));
    end

    assign found = |hit;
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_rt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  core_wr_t          wr,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] enable_q;
    logic [DATA_W-1:0] mbox_q [MBOX_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
            for (int k = 0; k < MBOX_N; k++) mbox_q[k] <= '0;
        end else if (wr.en) begin
            case (wr.ofs)
                OFS_ENABLE: enable_q <= wr.data;
                OFS_SET:    status_q <= status_q | wr.data;
                OFS_CLEAR:  status_q <= status_q & ~wr.data;
                default: begin
                    if (is_mbox(wr.ofs)) mbox_q[mbox_idx(wr.ofs)] <= wr.data;
                end
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_ofs)
            OFS_STATUS: rd_data = status_q;
            OFS_ENABLE: rd_data = enable_q;
            default: begin
                if (is_mbox(rd_ofs)) rd_data = mbox_q[mbox_idx(rd_ofs)];
            end
        endcase
    end

    assign irq = |(status_q & enable_q);
endmodule

// File: rtl/ipi_send_router.sv
module ipi_send_router
    import ipi_rt_pkg::*;
#(
    parameter int NUM_CORES = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [OFS_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [ID_W-1:0]      req_id,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_err,
    output logic [NUM_CORES-1:0] irq
);
    if (NUM_CORES < 1) begin : g_bad_param
        $error("NUM_CORES must be at least 1");
    end

    logic [NUM_CORES-1:0] req_hit;
    logic                 req_ok;
    logic [NUM_CORES-1:0] tgt_hit;
    logic                 tgt_ok;
    op_kind_e             op;
    logic                 send_go;
    logic [DATA_W-1:0]    send_mask;
    logic [DATA_W-1:0]    rd_bus [NUM_CORES];

    ipi_id_map #(.NUM_CORES(NUM_CORES)) u_req_map (
        .id    (req_id),
        .hit   (req_hit),
        .found (req_ok)
    );

    ipi_id_map #(.NUM_CORES(NUM_CORES)) u_tgt_map (
        .id    (req_wdata[TGT_LSB +: ID_W]),
        .hit   (tgt_hit),
        .found (tgt_ok)
    );

    assign op        = classify(req_valid, req_write, req_addr, req_ok);
    assign send_go   = (op == OP_SEND) && tgt_ok;
    assign send_mask = vec_to_mask(req_wdata[VEC_W-1:0]);
    assign rsp_err   = (op == OP_REJECT) || ((op == OP_SEND) && !tgt_ok);

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        core_wr_t          wr_c;
        logic [DATA_W-1:0] rd_c;

        always_comb begin
            wr_c = '0;
            if (send_go && tgt_hit[i]) begin
                wr_c.en   = 1'b1;
                wr_c.ofs  = OFS_SET;
                wr_c.data = send_mask;
            end else if ((op == OP_LOCAL_WR) && req_hit[i]) begin
                wr_c.en   = 1'b1;
                wr_c.ofs  = req_addr;
                wr_c.data = req_wdata;
            end
        end

        ipi_core_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr_c),
            .rd_ofs  (req_addr),
            .rd_data (rd_c),
            .irq     (irq[i])
        );

        assign rd_bus[i] = ((op == OP_LOCAL_RD) && req_hit[i]) ? rd_c : '0;
    end

    always_comb begin
        rsp_rdata = '0;
        for (int i = 0; i < NUM_CORES; i++) rsp_rdata = rsp_rdata | rd_bus[i];
    end
endmodule

// File: rtl/ipi_send_router_chk.sv
module ipi_send_router_chk
    import ipi_rt_pkg::*;
#(
    parameter int NUM_CORES = 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [OFS_W-1:0]     req_addr,
    input logic [DATA_W-1:0]    req_wdata,
    input logic [ID_W-1:0]      req_id,
    input logic                 rsp_err,
    input logic [NUM_CORES-1:0] irq
);
    logic bad_req;
    logic bad_send;
    assign bad_req  = req_valid && (32'(req_id) >= NUM_CORES);
    assign bad_send = req_valid && req_write && (req_addr == OFS_SEND)
                      && !bad_req && (32'(req_wdata[TGT_LSB +: ID_W]) >= NUM_CORES);

    AST_RESET_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq == '0));                                   // R1
    AST_BAD_ID_ERR: assert property (@(posedge clk) disable iff (rst)
        bad_req |-> rsp_err);                                          // R2
    AST_BAD_ID_HOLD: assert property (@(posedge clk) disable iff (rst)
        bad_req |=> $stable(irq));                                     // R2
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> $stable(irq));                   // R3
    AST_BAD_SEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        bad_send |=> $stable(irq));                                    // R8
    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !rsp_err);                                      // R8
endmodule

bind ipi_send_router ipi_send_router_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_id    (req_id),
    .rsp_err   (rsp_err),
    .irq       (irq)
);

// File: tb/test_ipi_send_router.sv
module test_ipi_send_router;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [9:0]  req_id = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [N-1:0] irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_st [N];
    logic [31:0] m_en [N];
    logic [31:0] m_mb [N][8];

    always #10 clk = ~clk;

    ipi_send_router #(.NUM_CORES(N)) i_ipi_send_router (
        .clk, .rst, .req_valid, .req_write, .req_addr, .req_wdata, .req_id,
        .rsp_rdata, .rsp_err, .irq
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [9:0] id, input logic [7:0] ofs);
        if (id >= N) return '0;
        case (ofs)
            8'h00: return m_st[id];
            8'h04: return m_en[id];
            default: begin
                if (ofs >= 8'h20 && ofs <= 8'h3C && ofs[1:0] == 2'b00)
                    return m_mb[id][ofs[4:2]];
                return '0;
            end
        endcase
    endfunction

    function automatic logic exp_err(input logic wr, input logic [7:0] ofs,
                                     input logic [9:0] id, input logic [31:0] d);
        if (id >= N) return 1'b1;
        if (wr && ofs == 8'h40 && d[25:16] >= N) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [N-1:0] exp_irq();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = |(m_st[i] & m_en[i]);
        return r;
    endfunction

    task automatic model_wr(input logic [7:0] ofs, input logic [9:0] id, input logic [31:0] d);
        case (ofs)
            8'h04: m_en[id] = d;
            8'h08: m_st[id] = m_st[id] | d;
            8'h0C: m_st[id] = m_st[id] & ~d;
            8'h40: m_st[d[25:16]] = m_st[d[25:16]] | (32'd1 << d[4:0]);
            default: begin
                if (ofs >= 8'h20 && ofs <= 8'h3C && ofs[1:0] == 2'b00)
                    m_mb[id][ofs[4:2]] = d;
            end
        endcase
    endtask

    task automatic do_op(input logic wr, input logic [7:0] ofs, input logic [9:0] id,
                         input logic [31:0] d, input string tag);
        logic e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ofs; req_id = id; req_wdata = d;
        #1;
        e = exp_err(wr, ofs, id, d);
        check({tag, " err"}, 32'(rsp_err), 32'(e));
        if (!wr) check({tag, " rdata"}, rsp_rdata, e ? 32'd0 : exp_rd(id, ofs));
        @(posedge clk);
        #1;
        if (wr && !e) model_wr(ofs, id, d);
        req_valid = 1'b0;
        check({tag, " irq"}, 32'(irq), 32'(exp_irq()));
    endtask

    function automatic logic [31:0] send_word(input logic [9:0] tgt, input logic [4:0] vec,
                                              input logic [31:0] junk);
        return (junk & ~32'h03FF_001F) | (32'(tgt) << 16) | 32'(vec);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] ofs_tab [9];
        void'($urandom(32'h5EED_1234));
        ofs_tab = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h20, 8'h2C, 8'h3C, 8'h40, 8'h14};
        for (int i = 0; i < N; i++) begin
            m_st[i] = '0; m_en[i] = '0;
            for (int k = 0; k < 8; k++) m_mb[i][k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state of every register and line
        #1 check("R1 irq", 32'(irq), 32'd0);
        for (int c = 0; c < N; c++) begin
            do_op(1'b0, 8'h00, 10'(c), 0, "R1 status");
            do_op(1'b0, 8'h04, 10'(c), 0, "R1 enable");
            do_op(1'b0, 8'h3C, 10'(c), 0, "R1 mailbox");
        end

        // R3 enable write and read back; R5 irq follows enable
        do_op(1'b1, 8'h04, 10'd1, 32'hFFFF_FFFF, "R3 enable wr");
        do_op(1'b0, 8'h04, 10'd1, 0, "R3 enable rd");
        // R7 send from core 0 to core 1, vector 31, junk bits set
        do_op(1'b1, 8'h40, 10'd0, send_word(10'd1, 5'd31, 32'hFFFF_FFFF), "R7 send v31");
        do_op(1'b0, 8'h00, 10'd1, 0, "R7 target status");
        do_op(1'b0, 8'h00, 10'd0, 0, "R7 sender untouched");
        // R9 send to self
        do_op(1'b1, 8'h04, 10'd2, 32'h0000_0001, "R9 enable");
        do_op(1'b1, 8'h40, 10'd2, send_word(10'd2, 5'd0, 32'h0), "R9 self send");
        do_op(1'b0, 8'h00, 10'd2, 0, "R9 self status");
        // R4 clear and set
        do_op(1'b1, 8'h0C, 10'd2, 32'h0000_0001, "R4 clear");
        do_op(1'b1, 8'h08, 10'd2, 32'h0000_0F00, "R4 set");
        do_op(1'b0, 8'h00, 10'd2, 0, "R4 status");
        // R8 bad targets
        do_op(1'b1, 8'h40, 10'd0, send_word(10'd3, 5'd2, 32'h0), "R8 target 3");
        do_op(1'b1, 8'h40, 10'd1, send_word(10'd1023, 5'd2, 32'h0), "R8 target 1023");
        // R2 bad requester changes nothing
        do_op(1'b1, 8'h04, 10'd3, 32'h0000_0F00, "R2 bad req wr");
        do_op(1'b1, 8'h08, 10'd1023, 32'hFFFF_FFFF, "R2 bad req set");
        do_op(1'b0, 8'h00, 10'd5, 0, "R2 bad req rd");
        for (int c = 0; c < N; c++) do_op(1'b0, 8'h04, 10'(c), 0, "R2 enable kept");
        // R10 status write and unmapped offset ignored
        do_op(1'b1, 8'h00, 10'd0, 32'hFFFF_FFFF, "R10 status wr");
        do_op(1'b1, 8'h14, 10'd0, 32'hFFFF_FFFF, "R10 unmapped wr");
        do_op(1'b0, 8'h00, 10'd0, 0, "R10 status kept");
        do_op(1'b0, 8'h14, 10'd0, 0, "R10 unmapped rd");
        // R11 write-only offsets read zero
        do_op(1'b0, 8'h08, 10'd2, 0, "R11 set rd");
        do_op(1'b0, 8'h0C, 10'd2, 0, "R11 clear rd");
        do_op(1'b0, 8'h40, 10'd2, 0, "R11 send rd");
        // R6 mailbox separation
        do_op(1'b1, 8'h24, 10'd0, 32'hA5A5_0000, "R6 mb core0");
        do_op(1'b1, 8'h24, 10'd1, 32'h0000_5A5A, "R6 mb core1");
        do_op(1'b0, 8'h24, 10'd0, 0, "R6 mb rd core0");
        do_op(1'b0, 8'h24, 10'd1, 0, "R6 mb rd core1");
        do_op(1'b0, 8'h24, 10'd2, 0, "R6 mb rd core2");

        // random mix, all requirements
        for (int n = 0; n < 3000; n++) begin
            logic [9:0]  id;
            logic [7:0]  ofs;
            logic [31:0] d;
            logic        wr;
            id  = ($urandom_range(0, 9) == 0) ? 10'($urandom_range(3, 1023)) : 10'($urandom_range(0, N - 1));
            ofs = ofs_tab[$urandom_range(0, 8)];
            wr  = 1'($urandom_range(0, 1));
            d   = $urandom;
            if (ofs == 8'h40 && wr) begin
                logic [9:0] t;
                t = ($urandom_range(0, 7) == 0) ? 10'($urandom_range(3, 1023)) : 10'($urandom_range(0, N - 1));
                d = send_word(t, 5'($urandom_range(0, 31)), $urandom);
            end
            if (ofs == 8'h08 && wr) d = 32'd1 << $urandom_range(0, 31);
            do_op(wr, ofs, id, d, "R5 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule